// File: doc/BRIEF.md
# Double-Width Funnel Right Shifter

This block joins two 64-bit operands into one 128-bit working value, with the high source in the upper half and the low source in the lower half. It shifts that value right by an unsigned 6-bit count and returns the lower 64 bits. A long shift across a register pair therefore costs a single operation. When the same word is driven on both sources, the bits that leave the low end come back in at the top, so the block also serves as a right rotate with no extra logic.

Operands are captured when `valid_in` is high, and the result appears on a registered output one cycle later. The result depends only on the operand values present in the issue cycle. A destination that is the same register as a source is therefore safe, and a new operation may issue in every cycle. The shift network is a chain of logarithmic stages. Each stage is sized to the bits it still needs to carry.

Top module: `funnel_shr`

## Requirements
- R1: In the first cycle after a synchronous active-low reset, `valid_out` is 0 and `result` is all zeros.
- R2: `valid_out` equals the value `valid_in` had at the previous rising clock edge.
- R3: One cycle after an issue, bit i of `result` (i = 0..63) equals bit (i + `shamt`) of the 128-bit value {`src_hi`, `src_lo`}, where `src_hi` occupies bits 127:64 and `src_lo` occupies bits 63:0.
- R4: An issue with `shamt` = 0 returns `src_lo` unchanged.
- R5: When `src_hi` equals `src_lo`, the result is that word rotated right by `shamt`: bit i of the result equals bit ((i + `shamt`) mod 64) of the word.
- R6: An issue with `shamt` = 63 returns `src_hi[62:0]` in bits 63:1 and `src_lo[63]` in bit 0.
- R7: In a cycle after an edge at which `valid_in` was low, `result` keeps its previous value, whatever the source and count inputs do.
- R8: Issues on consecutive cycles each produce their own result, in issue order, one cycle after the issue. Operand changes after the issue edge have no effect on that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Issue strobe; operands are sampled when high |
| src_hi | input | 64 | Upper half of the 128-bit working value |
| src_lo | input | 64 | Lower half of the 128-bit working value |
| shamt | input | 6 | Unsigned right-shift count, 0 to 63 |
| valid_out | output | 1 | High for one cycle per issue, one cycle late |
| result | output | 64 | Low 64 bits of the shifted working value |

## Verification
Every result and `valid_out` is due exactly one rising edge after the edge that sampled its issue. Idle cycles must leave `result` unchanged. The driver presents operands on the falling edge and pushes each expected word into a queue. The monitor samples 1 ns after every rising edge. It checks `valid_out` against the strobe captured at that edge, and on each valid it pops and compares the oldest queue entry. On an idle cycle it compares `result` with the last delivered word. Back-to-back issues, and source wiggling during idle cycles, therefore test both timing and sampling at issue.

// File: rtl/funnel_pkg.sv
// Package: shared widths and types for the funnel shifter.
// Assumes the word width is a power of two, so that the count width
// covers exactly 0 .. WORD_W-1.
package funnel_pkg;
    localparam int WORD_W = 64;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/funnel_stage.sv
// Module: funnel_stage
// One level of the logarithmic shifter. When sel is high, the window moves
// right by SHIFT bits; otherwise it keeps the low part. The output is SHIFT
// bits narrower than the input: the top bits can no longer reach the
// final word once this level is done.
// Assumes IN_W > SHIFT.
module funnel_stage #(
    parameter int IN_W  = 127,
    parameter int SHIFT = 32,
    localparam int OUT_W = IN_W - SHIFT
) (
    input  logic [IN_W-1:0]  din,
    input  logic             sel,
    output logic [OUT_W-1:0] dout
);
    // Purpose: pick the shifted or the unshifted window.
    always_comb begin
        if (sel) dout = din[IN_W-1:SHIFT];
        else     dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/funnel_core.sv
// Module: funnel_core
// Combinational funnel shift. It joins hi:lo into a 2*DATA_W value, shifts
// right by cnt and returns the low DATA_W bits. The stages run from the
// largest shift to the smallest, so each level carries only
// DATA_W + 2^k - 1 bits.
// Assumes DATA_W is a power of two and CNT_W = log2(DATA_W).
module funnel_core #(
    parameter int DATA_W = funnel_pkg::WORD_W,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] dout
);
    localparam int CAT_W = 2 * DATA_W;

    logic [CAT_W-1:0] cat;
    logic [CAT_W-1:0] ref_w;

    // Purpose: form the double-width working value.
    assign cat = {hi, lo};

    for (genvar k = 0; k < CNT_W; k++) begin : g_stg
        localparam int SH = 1 << k;
        localparam int IW = DATA_W + 2 * SH - 1;
        localparam int OW = DATA_W + SH - 1;
        logic [IW-1:0] d;
        logic [OW-1:0] q;

        if (k == CNT_W - 1) begin : g_first
            // Purpose: the top level takes all bits that any count can reach.
            assign d = cat[IW-1:0];
        end else begin : g_next
            // Purpose: the lower levels chain from the level above.
            assign d = g_stg[k+1].q;
        end

        funnel_stage #(.IN_W(IW), .SHIFT(SH)) u_stage (
            .din  (d),
            .sel  (cnt[k]),
            .dout (q)
        );
    end

    // Purpose: the last level is exactly one word wide.
    assign dout = g_stg[0].q;

    // Purpose: a flat wide shift, used only by the check below.
    assign ref_w = cat >> cnt;

    // Purpose: the staged network must agree with a flat wide shift (R3).
    always_comb begin
        if (!$isunknown({cat, cnt})) begin
            p_funnel_match_r3: assert (dout == ref_w[DATA_W-1:0]);
        end
    end
endmodule

// File: rtl/funnel_shr.sv
// Module: funnel_shr
// Top level. A funnel right shift of {src_hi, src_lo} by shamt, with a
// registered result and a one-cycle valid. Operands count only in the
// issue cycle. The result register holds its value while no issue is
// present.
// Assumes a synchronous active-low reset and DATA_W a power of two.
module funnel_shr #(
    parameter int DATA_W = funnel_pkg::WORD_W,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] src_hi,
    input  logic [DATA_W-1:0] src_lo,
    input  logic [CNT_W-1:0]  shamt,
    output logic              valid_out,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] shifted;

    funnel_core #(.DATA_W(DATA_W)) u_core (
        .hi   (src_hi),
        .lo   (src_lo),
        .cnt  (shamt),
        .dout (shifted)
    );

    // Purpose: capture the shifted word on issue and delay the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            result    <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) result <= shifted;
        end
    end

    // The strobe is delayed by exactly one cycle (R2).
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_out == $past(valid_in)));

    // With no issue at the last edge, the result does not move (R7).
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_in)) |-> $stable(result));

    // A zero count passes the low source through (R4).
    p_zero_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_in) && ($past(shamt) == '0))
        |-> (result == $past(src_lo)));

    // Equal sources give a right rotate (R5).
    p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_in) && ($past(src_hi) == $past(src_lo)))
        |-> (result == (($past(src_lo) >> $past(shamt))
                      | ($past(src_lo) << (DATA_W - int'($past(shamt)))))));
endmodule

// File: tb/funnel_shr_test.sv
module funnel_shr_test;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [W-1:0] src_hi = '0;
    logic [W-1:0] src_lo = '0;
    logic [5:0]   shamt = '0;
    logic         valid_out;
    logic [W-1:0] result;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;
    item_t sb[$];
    logic [W-1:0] last_res = '0;

    funnel_shr uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .src_hi(src_hi), .src_lo(src_lo), .shamt(shamt),
        .valid_out(valid_out), .result(result)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] wide_ref(input logic [W-1:0] h,
                                              input logic [W-1:0] l,
                                              input logic [5:0] c);
        logic [2*W-1:0] w;
        w = {h, l} >> c;
        return w[W-1:0];
    endfunction

    function automatic logic [W-1:0] rot_ref(input logic [W-1:0] v,
                                             input logic [5:0] c);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[(i + int'(c)) % W];
        return r;
    endfunction

    // Driver: presents one issue on the falling edge and queues its expectation.
    task automatic issue(input logic [W-1:0] h, input logic [W-1:0] l,
                         input logic [5:0] c, input logic [W-1:0] e,
                         input string tag);
        item_t it;
        @(negedge clk);
        valid_in = 1'b1;
        src_hi = h;
        src_lo = l;
        shamt = c;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Idle cycles that change the sources, which must have no effect (R7).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
            src_hi = {$urandom, $urandom};
            src_lo = {$urandom, $urandom};
            shamt = 6'($urandom);
        end
    endtask

    // Monitor: checks the strobe delay, pops the results and checks the hold.
    initial begin
        forever begin
            logic vin;
            logic rs;
            @(posedge clk);
            vin = valid_in;
            rs = rst_n;
            #1;
            if (rs && !done) begin
                check(valid_out == vin, "R2 valid delay", W'(valid_out), W'(vin));
                if (valid_out) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R8 unexpected result", result, '0);
                    end else begin
                        item_t it;
                        it = sb.pop_front();
                        check(result === it.exp, it.tag, result, it.exp);
                        last_res = it.exp;
                    end
                end else begin
                    check(result === last_res, "R7 idle hold", result, last_res);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] h, l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(valid_out == 1'b0 && result == '0, "R1 reset state",
              {result[W-2:0], valid_out}, '0);

        // R4: a zero count passes the low source through.
        issue(64'hFFFF_0000_1234_5678, 64'h0123_4567_89AB_CDEF, 6'd0,
              64'h0123_4567_89AB_CDEF, "R4 zero count");
        issue(64'h0, 64'hDEAD_BEEF_CAFE_F00D, 6'd0, 64'hDEAD_BEEF_CAFE_F00D,
              "R4 zero count");
        idle(2);

        // R3 and R8: every count, issued back to back.
        for (int c = 0; c < 64; c++) begin
            h = {$urandom, $urandom};
            l = {$urandom, $urandom};
            issue(h, l, 6'(c), wide_ref(h, l, 6'(c)), "R3/R8 funnel");
        end
        idle(3);

        // R3: sparse patterns that show the seam between the two halves.
        issue(64'h1, 64'h0, 6'd1, 64'h8000_0000_0000_0000, "R3 seam bit");
        issue(64'h0, 64'h8000_0000_0000_0001, 6'd63, 64'h1, "R3 low msb");
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd32, 64'hFFFF_FFFF_0000_0000,
              "R3 half");
        idle(1);

        // R5: equal sources give a rotate.
        for (int c = 0; c < 64; c += 7) begin
            h = {$urandom, $urandom};
            issue(h, h, 6'(c), rot_ref(h, 6'(c)), "R5 rotate");
        end
        issue(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 6'd1,
              64'hC000_0000_0000_0000, "R5 rotate wrap");
        idle(2);

        // R6: the largest count.
        h = 64'hA5A5_5A5A_0F0F_F0F0;
        l = 64'h8000_0000_0000_0000;
        issue(h, l, 6'd63, {h[62:0], l[63]}, "R6 count 63");
        l = 64'h7FFF_FFFF_FFFF_FFFF;
        issue(h, l, 6'd63, {h[62:0], l[63]}, "R6 count 63");

        // R7: a long idle stretch with moving sources.
        idle(6);
        repeat (2) @(posedge clk);
        #1;
        done = 1'b1;
        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8 pending results actual=%0d expected=0", sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule